// File: doc/BRIEF.md
# Byte-Wide Host Slave Port Controller

This block lets an external host exchange bytes with an on-chip CPU. The host uses a chip select, a read strobe, a write strobe and one address line. Host writes with the address line high land in an eight-byte receive queue. The CPU drains the queue through a small register bus. For the opposite direction, the CPU loads a single outgoing byte, which the host then reads.

All host strobes are asynchronous to the block clock. Each one passes through a two-flop synchroniser before the block acts on it. The instant at which write data is captured is set by a 3-bit delay field. The block shows empty, busy, error and ready flags to the CPU and raises one interrupt line. The error flag is shared between host writes into a full queue and host reads with no byte loaded.

CPU register addresses on `cpuAddr`: 0 is control, 1 is status, 2 is the receive queue (a read pops one byte), and 3 is the outgoing byte.

Top module: `hostSlavePort`

## Requirements
- R1: Control register layout: bit 7 enable, bit 6 busy-interrupt enable, bit 5 error-interrupt enable, bits 4:2 capture delay, bits 1:0 always read 0. The register resets to 0x00, and writing 0xFF reads back 0xFC.
- R2: While enable is 0, host strobes are ignored. No byte is queued, no flag changes, and the host data bus is not driven.
- R3: Take E0 as the first clock edge at which chip select and the write strobe are both low. With a delay field of d, the host data bus is captured at edge E(d+2). A field value of 0 behaves as 1.
- R4: The receive queue holds 8 bytes and returns them in arrival order. A CPU read of address 2 returns the oldest byte and removes it.
- R5: Status register layout: bit 7 empty, bit 6 busy, bit 5 error, bit 4 ready, bits 3:0 read 0. The empty bit is 1 exactly when the queue holds no bytes. After reset the status reads 0x80.
- R6: A host write that moves the queue from empty to one byte sets busy. A CPU write to status sets busy to bit 6 of the written value.
- R7: The error flag is set in either of two cases. One is a host write with address high into a full queue; that byte is dropped. The other is a host read with address high while ready is 0. The flag stays set until a CPU status write with bit 5 equal to 0 clears it.
- R8: A CPU write to address 3 stores the byte and sets ready. A host read with address high drives that byte. Ready clears when the synchronised read strobe ends.
- R9: irq equals (busy AND busy-interrupt enable) OR (error AND error-interrupt enable).
- R10: Host writes with the address line low queue nothing and set no flag.
- R11: A CPU read of address 2 while the queue is empty returns 0 and changes no state.
- R12: A write strobe held low for many cycles queues exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostA0 | input | 1 | Host address line; high selects the data path |
| hostDin | input | 8 | Host write data |
| hostDout | output | 8 | Outgoing byte presented to the host |
| hostDoe | output | 1 | Output enable for hostDout |
| cpuAddr | input | 2 | CPU register address |
| cpuWe | input | 1 | CPU write strobe |
| cpuRe | input | 1 | CPU read strobe (pops the queue at address 2) |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data for the current address |
| irq | output | 1 | Interrupt to the CPU |

## Verification
The bench sweeps all eight delay codes. While the write strobe is held low, it changes the host data bus on every cycle, so the captured byte shows the exact capture edge. A design off by one would pull the neighbouring value, and one that treats code 0 as zero delay would take the wrong byte. The queue is filled past its depth and then drained. A design that overwrote old data or failed to flag the drop would return the wrong order or leave the error bit clear. Further checks cover reads of an empty queue, host reads with nothing loaded, strobes with the address line low, and activity while disabled. Each of these must leave the status unchanged or set exactly the one error bit; a design that leaks would show a stray flag or a spurious interrupt.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int REG_W = 8;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_RXQ  = 2'd2;
  localparam logic [1:0] ADDR_TXB  = 2'd3;

  typedef struct packed {
    logic             push;
    logic [REG_W-1:0] pushData;
    logic             readStart;
    logic             readEnd;
  } hspStrobes_t;
endpackage

// File: rtl/hspCtrl.sv
module hspCtrl
  import hsp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [2:0]       delaySel,
  input  logic             hostCsN,
  input  logic             hostRdN,
  input  logic             hostWrN,
  input  logic             hostA0,
  input  logic [REG_W-1:0] hostDin,
  output hspStrobes_t      str
);
  localparam int NPIN = 3;

  logic [NPIN-1:0] rawPins;
  logic [NPIN-1:0] syncPins;
  assign rawPins = {hostCsN, hostRdN, hostWrN};

  // One synchroniser chain per host strobe; idle level is high.
  for (genvar p = 0; p < NPIN; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawPins[p]};
    end
    assign syncPins[p] = chain[SYNC_STAGES-1];
  end

  logic csS, rdS, wrS;
  assign csS = syncPins[2];
  assign rdS = syncPins[1];
  assign wrS = syncPins[0];

  logic wrAct, wrPrev, wrRise;
  logic rdAct, rdPrev, rdRise, rdFall;
  logic rdA0;
  logic [2:0] waitCnt;
  logic [2:0] delayEff;

  assign wrAct    = en & ~csS & ~wrS;
  assign rdAct    = en & ~csS & ~rdS;
  assign wrRise   = wrAct & ~wrPrev;
  assign rdRise   = rdAct & ~rdPrev;
  assign rdFall   = ~rdAct & rdPrev;
  assign delayEff = (delaySel == 3'd0) ? 3'd1 : delaySel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev  <= 1'b0;
      rdPrev  <= 1'b0;
      rdA0    <= 1'b0;
      waitCnt <= '0;
    end else begin
      wrPrev <= wrAct;
      rdPrev <= rdAct;
      if (rdRise) rdA0 <= hostA0;
      if (!en)               waitCnt <= '0;
      else if (wrRise)       waitCnt <= delayEff;
      else if (waitCnt != 0) waitCnt <= waitCnt - 3'd1;
    end
  end

  always_comb begin
    str           = '0;
    str.push      = en & (waitCnt == 3'd1) & hostA0;
    str.pushData  = hostDin;
    str.readStart = rdRise & hostA0;
    str.readEnd   = en & rdFall & rdA0;
  end

  // R12: a capture is a single-cycle event per strobe
  a_r12_single_push: assert property (@(posedge clk) disable iff (!rstN)
    str.push |=> !str.push);
  // R2: with the port disabled no host event reaches the datapath
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!en && !$past(en)) |-> !(str.push || str.readStart));
endmodule

// File: rtl/hspData.sv
module hspData
  import hsp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  hspStrobes_t      str,
  input  logic [1:0]       cpuAddr,
  input  logic             cpuWe,
  input  logic             cpuRe,
  input  logic [REG_W-1:0] cpuWdata,
  output logic [REG_W-1:0] cpuRdata,
  output logic             en,
  output logic [2:0]       delaySel,
  output logic             readyFlag,
  output logic [REG_W-1:0] txByte,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic busyIe, errIe;
  logic busyFlag, errFlag;
  logic [REG_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;

  logic full, emptyQ, doPush, doPop;
  logic wrCtrl, wrStat, wrTx;

  assign full   = (count == FULL_CNT);
  assign emptyQ = (count == '0);
  assign doPush = str.push & ~full;
  assign doPop  = cpuRe & (cpuAddr == ADDR_RXQ) & ~emptyQ;
  assign wrCtrl = cpuWe & (cpuAddr == ADDR_CTRL);
  assign wrStat = cpuWe & (cpuAddr == ADDR_STAT);
  assign wrTx   = cpuWe & (cpuAddr == ADDR_TXB);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= str.pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en        <= 1'b0;
      busyIe    <= 1'b0;
      errIe     <= 1'b0;
      delaySel  <= '0;
      busyFlag  <= 1'b0;
      errFlag   <= 1'b0;
      readyFlag <= 1'b0;
      txByte    <= '0;
    end else begin
      if (wrCtrl) begin
        en       <= cpuWdata[7];
        busyIe   <= cpuWdata[6];
        errIe    <= cpuWdata[5];
        delaySel <= cpuWdata[4:2];
      end
      // hardware events take priority over software writes
      if (doPush && emptyQ)  busyFlag <= 1'b1;
      else if (wrStat)       busyFlag <= cpuWdata[6];
      if ((str.push && full) || (str.readStart && !readyFlag)) errFlag <= 1'b1;
      else if (wrStat && !cpuWdata[5])                          errFlag <= 1'b0;
      if (wrTx) begin
        txByte    <= cpuWdata;
        readyFlag <= 1'b1;
      end else if (str.readEnd) begin
        readyFlag <= 1'b0;
      end
    end
  end

  always_comb begin
    case (cpuAddr)
      ADDR_CTRL: cpuRdata = {en, busyIe, errIe, delaySel, 2'b00};
      ADDR_STAT: cpuRdata = {emptyQ, busyFlag, errFlag, readyFlag, 4'b0000};
      ADDR_RXQ:  cpuRdata = emptyQ ? '0 : mem[rdPtr];
      default:   cpuRdata = txByte;
    endcase
  end

  assign irq = (busyFlag & busyIe) | (errFlag & errIe);

  // R4: occupancy never exceeds the queue depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R7: a host write into a full queue is dropped and flagged
  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (str.push && full && !doPop) |=> (errFlag && full));
  // R6: first byte into an empty queue raises busy
  a_r6_busy_on_first: assert property (@(posedge clk) disable iff (!rstN)
    (str.push && emptyQ) |=> busyFlag);
  // R8: end of a host read clears ready unless reloaded
  a_r8_ready_clears: assert property (@(posedge clk) disable iff (!rstN)
    (str.readEnd && !wrTx) |=> !readyFlag);
  // R11: a pop of an empty queue leaves it empty
  a_r11_empty_pop: assert property (@(posedge clk) disable iff (!rstN)
    (emptyQ && !str.push && cpuRe && cpuAddr == ADDR_RXQ) |=> emptyQ);
endmodule

// File: rtl/hostSlavePort.sv
module hostSlavePort
  import hsp_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostCsN,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic       hostA0,
  input  logic [7:0] hostDin,
  output logic [7:0] hostDout,
  output logic       hostDoe,
  input  logic [1:0] cpuAddr,
  input  logic       cpuWe,
  input  logic       cpuRe,
  input  logic [7:0] cpuWdata,
  output logic [7:0] cpuRdata,
  output logic       irq
);
  hspStrobes_t str;
  logic       en;
  logic [2:0] delaySel;
  logic       readyFlag;

  hspCtrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .en(en), .delaySel(delaySel),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostA0(hostA0), .hostDin(hostDin), .str(str)
  );

  hspData #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .str(str),
    .cpuAddr(cpuAddr), .cpuWe(cpuWe), .cpuRe(cpuRe),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .en(en), .delaySel(delaySel), .readyFlag(readyFlag),
    .txByte(hostDout), .irq(irq)
  );

  assign hostDoe = en & ~hostCsN & ~hostRdN & hostA0;

  // R2: bus is never driven while disabled
  a_r2_no_drive_off: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> !hostDoe);
endmodule

// File: tb/sim_hostSlavePort.sv
`timescale 1ns/1ps
module sim_hostSlavePort;
  logic clk = 0;
  logic rstN = 0;
  logic hostCsN = 1, hostRdN = 1, hostWrN = 1, hostA0 = 1;
  logic [7:0] hostDin = 0;
  logic [7:0] hostDout;
  logic hostDoe;
  logic [1:0] cpuAddr = 0;
  logic cpuWe = 0, cpuRe = 0;
  logic [7:0] cpuWdata = 0;
  logic [7:0] cpuRdata;
  logic irq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  hostSlavePort u0 (
    .clk(clk), .rstN(rstN), .hostCsN(hostCsN), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostA0(hostA0), .hostDin(hostDin),
    .hostDout(hostDout), .hostDoe(hostDoe), .cpuAddr(cpuAddr),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuWdata = d; cpuWe = 1;
    @(negedge clk);
    cpuWe = 0;
  endtask

  task automatic cpuRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuRe = 1;
    #1 d = cpuRdata;
    @(negedge clk);
    cpuRe = 0;
  endtask

  // Holds the write strobe for 12 edges; data before edge Ei is base+i when ramp=1
  task automatic hostWrite(input logic [7:0] d, input logic a0, input bit ramp);
    @(negedge clk);
    hostA0 = a0; hostDin = d; hostCsN = 0; hostWrN = 0;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (ramp) hostDin = d + 8'(i);
    end
    hostCsN = 1; hostWrN = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic hostRead(input logic a0, output logic [7:0] d, output logic oe);
    @(negedge clk);
    hostA0 = a0; hostCsN = 0; hostRdN = 0;
    repeat (4) @(negedge clk);
    d = hostDout; oe = hostDoe;
    repeat (2) @(negedge clk);
    hostCsN = 1; hostRdN = 1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic oe;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 / R5 reset values
    cpuRead(2'd0, v); check("R1 reset ctrl", v, 8'h00);
    cpuRead(2'd1, v); check("R5 reset status", v, 8'h80);
    check("R9 reset irq", {7'd0, irq}, 8'h00);
    cpuWrite(2'd0, 8'hFF); cpuRead(2'd0, v); check("R1 readback", v, 8'hFC);
    cpuWrite(2'd0, 8'h00);

    // R2 disabled: nothing happens
    hostWrite(8'h33, 1'b1, 0);
    cpuRead(2'd1, v); check("R2 status after write", v, 8'h80);
    hostRead(1'b1, v, oe);
    check("R2 no drive", {7'd0, oe}, 8'h00);
    cpuRead(2'd1, v); check("R2 status after read", v, 8'h80);

    // R3 capture delay sweep (code 0 behaves as 1)
    for (int ws = 0; ws < 8; ws++) begin
      int de;
      de = (ws == 0) ? 1 : ws;
      cpuWrite(2'd0, 8'h80 | 8'(ws << 2));
      hostWrite(8'h40, 1'b1, 1);
      cpuRead(2'd2, v); check($sformatf("R3 delay %0d", ws), v, 8'h40 + 8'(de + 2));
      cpuWrite(2'd1, 8'h00);
    end

    // R10 address-low write ignored; R12 one byte per long strobe
    cpuWrite(2'd0, 8'h84);
    hostWrite(8'h55, 1'b0, 0);
    cpuRead(2'd1, v); check("R10 status", v, 8'h80);
    hostWrite(8'h66, 1'b1, 0);
    cpuRead(2'd2, v); check("R12 byte", v, 8'h66);
    cpuRead(2'd1, v); check("R12 single push", v, 8'hC0);
    cpuWrite(2'd1, 8'h00);

    // R4/R6/R7 fill, overflow, drain
    for (int i = 0; i < 8; i++) hostWrite(8'h20 + 8'(i), 1'b1, 0);
    cpuRead(2'd1, v); check("R6 busy set, R5 not empty", v, 8'h40);
    hostWrite(8'h99, 1'b1, 0);
    cpuRead(2'd1, v); check("R7 overrun flag", v, 8'h60);
    for (int i = 0; i < 8; i++) begin
      cpuRead(2'd2, v); check($sformatf("R4 order %0d", i), v, 8'h20 + 8'(i));
    end
    cpuRead(2'd1, v); check("R5 empty again", v, 8'hE0);
    cpuRead(2'd2, v); check("R11 empty pop", v, 8'h00);
    cpuRead(2'd1, v); check("R11 status kept", v, 8'hE0);
    cpuWrite(2'd1, 8'h20); cpuRead(2'd1, v); check("R7 sticky on bit5=1", v, 8'hA0);
    cpuWrite(2'd1, 8'h00); cpuRead(2'd1, v); check("R7 cleared", v, 8'h80);
    cpuWrite(2'd1, 8'h40); cpuRead(2'd1, v); check("R6 software set", v, 8'hC0);
    cpuWrite(2'd1, 8'h00);

    // R8 outgoing byte
    cpuWrite(2'd3, 8'h5A);
    cpuRead(2'd1, v); check("R8 ready set", v, 8'h90);
    hostRead(1'b1, v, oe);
    check("R8 host data", v, 8'h5A);
    check("R8 drive enable", {7'd0, oe}, 8'h01);
    cpuRead(2'd1, v); check("R8 ready cleared", v, 8'h80);

    // R7 underrun and R9 interrupt
    cpuWrite(2'd0, 8'hA4);
    check("R9 idle irq", {7'd0, irq}, 8'h00);
    hostRead(1'b1, v, oe);
    cpuRead(2'd1, v); check("R7 underrun", v, 8'hA0);
    check("R9 error irq", {7'd0, irq}, 8'h01);
    cpuWrite(2'd1, 8'h00);
    check("R9 irq cleared", {7'd0, irq}, 8'h00);
    cpuWrite(2'd0, 8'hC4);
    hostWrite(8'h11, 1'b1, 0);
    check("R9 busy irq", {7'd0, irq}, 8'h01);
    cpuWrite(2'd0, 8'h84);
    check("R9 busy masked", {7'd0, irq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule